// File: doc/BRIEF.md
# Store-Triggered Latched Interrupt Controller

This block sits beside a CPU on a simple valid/ready memory bus and converts stores into interrupt requests. Two address windows, selected by the top byte of the address, act as doorbells: a store to the first window raises request line 30, and a store to the second window raises request line 31. The data written does not matter. A request is latched and stays pending until the CPU finishes servicing it.

A mask register, where a 1 disables a line, decides which pending lines can interrupt the CPU. When the CPU accepts an interrupt, the block records which lines are being serviced and reports them as a bitmask. It also presents the fixed handler address and keeps the return address that the CPU supplied. Both lines share one handler. While that handler runs, no further interrupt is offered. A return-from-interrupt pulses end-of-interrupt for the serviced lines and clears their pending latches. Requests that arrived in the meantime are then delivered.

Top module: `doorbell_irq_ctrl`

## Requirements
- R1: A bus access with address bits [31:24] equal to 0xe0 targets line 30. One with bits [31:24] equal to 0xe1 targets line 31. Any other prefix targets no line.
- R2: An access with at least one `bus_wstrb` bit set is a write and sets the target line's pending bit for any data value. An access with `bus_wstrb` equal to 0 is a read: it returns zero on `bus_rdata` and sets nothing.
- R3: `bus_ready` is high in the same cycle as `bus_valid` for an access to either window, with no wait state. It stays low for addresses outside both windows.
- R4: A pending bit set by a single-cycle write stays set for any number of cycles until an end-of-interrupt clears it.
- R5: A mask bit of 1 disables its line. `irq_req` is high only when at least one pending line has its mask bit at 0. Lines other than 30 and 31 can never be pending or requested.
- R6: When `irq_take` is high while `irq_req` is high, the block enters the active state on the next edge. In that state `irq_bits` shows every pending, unmasked line as a 1, `handler_pc` reads 0x00000010, and `ret_addr` holds the `cpu_pc` value sampled at the take.
- R7: `cpu_retirq` while active ends the handler at the next edge. `eoi` then equals the serviced bitmask for exactly one cycle, and those pending bits are cleared.
- R8: While active, `irq_req` stays low. Lines set during the handler stay pending and are requested after the return if they are unmasked.
- R9: After reset, no bit is pending, every line is masked, no handler is active, and `eoi` is zero.
- R10: A write that sets a pending bit in the same cycle as the end-of-interrupt clear for that bit leaves the bit set.
- R11: A pending line that is masked at the take is not serviced, and it stays pending after the return.
- R12: If both windows are written before the take, lines 30 and 31 appear together in one `irq_bits` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access valid |
| bus_addr | input | 32 | Bus byte address |
| bus_wstrb | input | 4 | Byte write strobes; zero means read |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_ready | output | 1 | Access to a window accepted |
| bus_rdata | output | 32 | Read data, always zero |
| mask_wr | input | 1 | Load the mask register |
| mask_wdata | input | 32 | New mask value; 1 disables a line |
| irq_take | input | 1 | CPU accepts the offered interrupt |
| cpu_pc | input | 32 | Return address sampled at the take |
| cpu_retirq | input | 1 | CPU return-from-interrupt |
| irq_req | output | 1 | Interrupt offered to the CPU |
| irq_active | output | 1 | Handler in progress |
| irq_bits | output | 32 | Serviced-line bitmask |
| handler_pc | output | 32 | Handler address |
| ret_addr | output | 32 | Saved return address |
| eoi | output | 32 | End-of-interrupt pulse per serviced line |
| irq_pending | output | 32 | Latched pending lines |

## Verification
A stuck or wrongly cleared pending latch shows on `irq_pending` on the first falling edge after the store or the return. It also shows as a missing or extra `irq_req`. A wrong mask or a wrong active flag shows on `irq_req` in the same cycle, because that output is combinational from the state. A stale serviced snapshot shows on `irq_bits` one cycle after the take. It also shows on `eoi` one cycle after the return, so every fault is visible at the ports within one clock of the event that exposes it.

// File: rtl/doorbell_irq_pkg.sv
// Package: shared widths, window geometry and derived line masks for the
// store-triggered interrupt controller. Assumes the windows use consecutive
// address prefixes and map to consecutive request lines.
package doorbell_irq_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int STRB_W    = 4;
    localparam int IRQ_W     = 32;
    localparam int PREFIX_W  = 8;
    localparam int NUM_WIN   = 2;
    localparam int FIRST_LINE = 30;
    localparam logic [PREFIX_W-1:0] FIRST_PREFIX = 8'he0;
    localparam logic [ADDR_W-1:0]   HANDLER_ADDR = 32'h0000_0010;

    typedef logic [IRQ_W-1:0] irq_vec_t;

    // Address prefix decoded for window w.
    function automatic logic [PREFIX_W-1:0] win_prefix(input int w);
        return FIRST_PREFIX + PREFIX_W'(w);
    endfunction

    // Request line raised by window w.
    function automatic int win_line(input int w);
        return FIRST_LINE + w;
    endfunction

    // One bit for every line that a window can raise.
    function automatic irq_vec_t line_mask();
        irq_vec_t m;
        m = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            m[win_line(w)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/doorbell_decode.sv
// Module: address decode for the doorbell windows. It produces a
// zero-wait-state ready and a one-cycle set vector for the lines whose window
// is written. Assumes the bus holds its inputs stable for the cycle of the
// access. Reads select a window but set nothing.
module doorbell_decode
    import doorbell_irq_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int S_W = STRB_W,
    parameter int N_W = NUM_WIN
) (
    input  logic           bus_valid,
    input  logic [A_W-1:0] bus_addr,
    input  logic [S_W-1:0] bus_wstrb,
    output logic           bus_ready,
    output irq_vec_t       set_vec
);
    localparam int PFX_LSB = A_W - PREFIX_W;

    logic [N_W-1:0] hit;
    logic           is_write;
    logic           unused_low;

    assign unused_low = ^bus_addr[PFX_LSB-1:0];

    // Per-window prefix compare.
    for (genvar w = 0; w < N_W; w++) begin : g_win
        assign hit[w] = bus_valid && (bus_addr[A_W-1:PFX_LSB] == win_prefix(w));
    end

    // Any strobe bit makes the access a write.
    assign is_write  = |bus_wstrb;
    assign bus_ready = |hit;

    // Build the set vector from the window hits.
    always_comb begin
        set_vec = '0;
        for (int w = 0; w < N_W; w++) begin
            set_vec[win_line(w)] = hit[w] & is_write;
        end
    end

endmodule

// File: rtl/doorbell_pending.sv
// Module: bank of latched pending bits. Only lines that a window can raise get
// a flop; the rest read as constant zero. A set in the same cycle as a clear
// wins, so a fresh request is never lost.
module doorbell_pending
    import doorbell_irq_pkg::*;
#(
    parameter int N = IRQ_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t set_vec,
    input  irq_vec_t clr_vec,
    output irq_vec_t pend_q
);
    localparam irq_vec_t LATCHED = line_mask();

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LATCHED[i]) begin : g_latch
            // Hold the request until cleared; a set overrides a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q[i] <= 1'b0;
                else        pend_q[i] <= set_vec[i] | (pend_q[i] & ~clr_vec[i]);
            end
        end else begin : g_tied
            logic unused_bit;
            assign unused_bit = set_vec[i] ^ clr_vec[i];
            assign pend_q[i]  = 1'b0;
        end
    end

endmodule

// File: rtl/doorbell_service.sv
// Module: mask register and handler state. It offers an interrupt when an
// unmasked line is pending and no handler is active. It snapshots the serviced
// lines and the return address at the take, and it clears the serviced lines
// and pulses end-of-interrupt on the return. Assumes the CPU raises irq_take
// only while irq_req is high; a take at any other time is ignored.
module doorbell_service
    import doorbell_irq_pkg::*;
#(
    parameter int A_W = ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  irq_vec_t       pend_q,
    input  logic           mask_wr,
    input  irq_vec_t       mask_wdata,
    input  logic           irq_take,
    input  logic [A_W-1:0] cpu_pc,
    input  logic           cpu_retirq,
    output logic           irq_req,
    output logic           irq_active,
    output irq_vec_t       irq_bits,
    output logic [A_W-1:0] ret_addr,
    output irq_vec_t       eoi,
    output irq_vec_t       clr_vec
);
    localparam irq_vec_t LATCHED = line_mask();

    irq_vec_t mask_q;
    irq_vec_t eligible;
    logic     take_fire;
    logic     ret_fire;

    // Lines without a window are always masked.
    assign eligible  = pend_q & ~(mask_q | ~LATCHED);
    assign irq_req   = !irq_active && (|eligible);
    assign take_fire = irq_take && irq_req;
    assign ret_fire  = cpu_retirq && irq_active;
    assign clr_vec   = ret_fire ? irq_bits : '0;

    // Mask register; reset disables every line.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Handler active flag and serviced-line snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_active <= 1'b0;
            irq_bits   <= '0;
        end else if (take_fire) begin
            irq_active <= 1'b1;
            irq_bits   <= eligible;
        end else if (ret_fire) begin
            irq_active <= 1'b0;
            irq_bits   <= '0;
        end
    end

    // Return address captured at the take.
    always_ff @(posedge clk) begin
        if (!rst_n)         ret_addr <= '0;
        else if (take_fire) ret_addr <= cpu_pc;
    end

    // One-cycle end-of-interrupt pulse for the serviced lines.
    always_ff @(posedge clk) begin
        if (!rst_n) eoi <= '0;
        else        eoi <= clr_vec;
    end

endmodule

// File: rtl/doorbell_irq_ctrl.sv
// Module: top of the store-triggered latched interrupt controller. It joins
// the window decode, the pending latches and the handler state. Window reads
// return zero. Assumes a single-cycle bus protocol in which ready is sampled
// in the same cycle as valid.
module doorbell_irq_ctrl
    import doorbell_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STRB_W-1:0] bus_wstrb,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              mask_wr,
    input  logic [IRQ_W-1:0]  mask_wdata,
    input  logic              irq_take,
    input  logic [ADDR_W-1:0] cpu_pc,
    input  logic              cpu_retirq,
    output logic              irq_req,
    output logic              irq_active,
    output logic [IRQ_W-1:0]  irq_bits,
    output logic [ADDR_W-1:0] handler_pc,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [IRQ_W-1:0]  eoi,
    output logic [IRQ_W-1:0]  irq_pending
);
    irq_vec_t set_vec;
    irq_vec_t clr_vec;
    logic     unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign bus_rdata    = '0;
    assign handler_pc   = HANDLER_ADDR;

    doorbell_decode u_decode (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_wstrb (bus_wstrb),
        .bus_ready (bus_ready),
        .set_vec   (set_vec)
    );

    doorbell_pending u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend_q  (irq_pending)
    );

    doorbell_service u_service (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_q     (irq_pending),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .irq_take   (irq_take),
        .cpu_pc     (cpu_pc),
        .cpu_retirq (cpu_retirq),
        .irq_req    (irq_req),
        .irq_active (irq_active),
        .irq_bits   (irq_bits),
        .ret_addr   (ret_addr),
        .eoi        (eoi),
        .clr_vec    (clr_vec)
    );

endmodule

// File: rtl/doorbell_irq_checker.sv
// Module: assertion checker bound to the controller top. It observes ports
// only.
module doorbell_irq_checker
    import doorbell_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [STRB_W-1:0] bus_wstrb,
    input logic              bus_ready,
    input logic              cpu_retirq,
    input logic              irq_req,
    input logic              irq_active,
    input logic [IRQ_W-1:0]  irq_bits,
    input logic [IRQ_W-1:0]  eoi,
    input logic [IRQ_W-1:0]  irq_pending
);
    localparam int LA = win_line(0);

    // R3: a window access is ready in the same cycle.
    a_r3_ready_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_addr[ADDR_W-1:ADDR_W-PREFIX_W] == win_prefix(1))) |-> bus_ready);

    // R2: a write to the first window sets its line by the next cycle.
    a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (|bus_wstrb) && (bus_addr[ADDR_W-1:ADDR_W-PREFIX_W] == win_prefix(0)))
        |=> irq_pending[LA]);

    // R4: a pending line holds unless a return clears it.
    a_r4_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending[LA] && !(irq_active && cpu_retirq)) |=> irq_pending[LA]);

    // R8: no interrupt is offered while a handler runs.
    a_r8_no_req_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq_active |-> !irq_req);

    // R6: a new handler services a non-empty subset of pending lines.
    a_r6_bits_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_active) |-> ((irq_bits != '0) && ((irq_bits & ~irq_pending) == '0)));

    // R7: a return ends the handler and pulses eoi with the serviced lines.
    a_r7_eoi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active && cpu_retirq) |=> (!irq_active && (eoi == $past(irq_bits))));

endmodule

bind doorbell_irq_ctrl doorbell_irq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_addr    (bus_addr),
    .bus_wstrb   (bus_wstrb),
    .bus_ready   (bus_ready),
    .cpu_retirq  (cpu_retirq),
    .irq_req     (irq_req),
    .irq_active  (irq_active),
    .irq_bits    (irq_bits),
    .eoi         (eoi),
    .irq_pending (irq_pending)
);

// File: tb/doorbell_irq_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module doorbell_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        mask_wr = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        irq_take = 1'b0;
    logic [31:0] cpu_pc = '0;
    logic        cpu_retirq = 1'b0;
    logic        irq_req;
    logic        irq_active;
    logic [31:0] irq_bits;
    logic [31:0] handler_pc;
    logic [31:0] ret_addr;
    logic [31:0] eoi;
    logic [31:0] irq_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] B30 = 32'h4000_0000;
    localparam logic [31:0] B31 = 32'h8000_0000;
    localparam logic [31:0] A30 = 32'he000_0000;
    localparam logic [31:0] A31 = 32'he100_0000;

    always #4 clk = ~clk;

    doorbell_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .irq_take(irq_take), .cpu_pc(cpu_pc), .cpu_retirq(cpu_retirq),
        .irq_req(irq_req), .irq_active(irq_active), .irq_bits(irq_bits),
        .handler_pc(handler_pc), .ret_addr(ret_addr), .eoi(eoi),
        .irq_pending(irq_pending)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One bus cycle starting at a falling edge; returns ready and rdata.
    task automatic bus_cycle(input logic [31:0] a, input logic [3:0] s, input logic [31:0] d,
                             output logic rdy, output logic [31:0] rd);
        bus_valid = 1'b1; bus_addr = a; bus_wstrb = s; bus_wdata = d;
        #1;
        rdy = bus_ready; rd = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0; bus_wstrb = '0;
    endtask

    task automatic set_mask(input logic [31:0] m);
        mask_wr = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic take(input logic [31:0] pc);
        irq_take = 1'b1; cpu_pc = pc;
        @(negedge clk);
        irq_take = 1'b0;
    endtask

    task automatic ret();
        cpu_retirq = 1'b1;
        @(negedge clk);
        cpu_retirq = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R9 pending", irq_pending, 32'h0);
        check("R9 active", {31'b0, irq_active}, 32'h0);
        check("R9 req", {31'b0, irq_req}, 32'h0);
        check("R9 eoi", eoi, 32'h0);
        // Reset masks every line: a pending line gives no request.
        begin
            logic r; logic [31:0] d;
            bus_cycle(A30, 4'b1111, 32'h1, r, d);
        end
        check("R9 masked after reset", {31'b0, irq_req}, 32'h0);
    endtask

    task automatic t_decode_latch();
        logic r; logic [31:0] d;
        do_reset();
        bus_cycle(A30 | 32'h0000_1234, 4'b0001, 32'h0, r, d);
        check("R3 ready win30", {31'b0, r}, 32'h1);
        check("R2 rdata zero", d, 32'h0);
        check("R1 line30 set", irq_pending, B30);
        bus_cycle(A31 | 32'h00ff_fffc, 4'b1000, 32'hffff_ffff, r, d);
        check("R3 ready win31", {31'b0, r}, 32'h1);
        check("R1 line31 set", irq_pending, B30 | B31);
        repeat (6) @(negedge clk);
        check("R4 latched hold", irq_pending, B30 | B31);
    endtask

    task automatic t_ignored_accesses();
        logic r; logic [31:0] d;
        do_reset();
        bus_cycle(A31, 4'b0000, 32'h0, r, d);
        check("R2 read ready", {31'b0, r}, 32'h1);
        check("R2 read data", d, 32'h0);
        check("R2 read sets nothing", irq_pending, 32'h0);
        bus_cycle(32'he200_0000, 4'b1111, 32'h0, r, d);
        check("R3 no ready e2", {31'b0, r}, 32'h0);
        check("R1 e2 sets nothing", irq_pending, 32'h0);
        bus_cycle(32'hdf00_0000, 4'b1111, 32'h0, r, d);
        check("R1 df sets nothing", irq_pending, 32'h0);
    endtask

    task automatic t_mask();
        logic r; logic [31:0] d;
        do_reset();
        set_mask(32'h0);
        check("R5 no pending no req", {31'b0, irq_req}, 32'h0);
        set_mask(32'hffff_ffff);
        bus_cycle(A30, 4'b0010, 32'h0, r, d);
        check("R5 masked no req", {31'b0, irq_req}, 32'h0);
        set_mask(32'hbfff_ffff);
        check("R5 line30 enabled", {31'b0, irq_req}, 32'h1);
        set_mask(32'h7fff_ffff);
        check("R5 only line31 enabled", {31'b0, irq_req}, 32'h0);
        set_mask(32'h0);
        check("R5 all clear", {31'b0, irq_req}, 32'h1);
    endtask

    task automatic t_take_return();
        logic r; logic [31:0] d;
        do_reset();
        set_mask(32'h3fff_ffff);
        bus_cycle(A31, 4'b0100, 32'h5a5a_5a5a, r, d);
        check("R5 req line31", {31'b0, irq_req}, 32'h1);
        take(32'h0000_0400);
        check("R6 active", {31'b0, irq_active}, 32'h1);
        check("R6 bits", irq_bits, B31);
        check("R6 handler", handler_pc, 32'h0000_0010);
        check("R6 ret addr", ret_addr, 32'h0000_0400);
        check("R8 no req active", {31'b0, irq_req}, 32'h0);
        ret();
        check("R7 inactive", {31'b0, irq_active}, 32'h0);
        check("R7 eoi", eoi, B31);
        check("R7 cleared", irq_pending, 32'h0);
        @(negedge clk);
        check("R7 eoi one cycle", eoi, 32'h0);
    endtask

    task automatic t_both_together();
        logic r; logic [31:0] d;
        do_reset();
        set_mask(32'h3fff_ffff);
        bus_cycle(A30, 4'b1111, 32'h0, r, d);
        bus_cycle(A31, 4'b1111, 32'h0, r, d);
        take(32'h0000_0120);
        check("R12 both bits", irq_bits, B30 | B31);
        ret();
        check("R12 eoi both", eoi, B30 | B31);
        check("R12 both cleared", irq_pending, 32'h0);
    endtask

    task automatic t_wait_during_handler();
        logic r; logic [31:0] d;
        do_reset();
        set_mask(32'h3fff_ffff);
        bus_cycle(A30, 4'b0001, 32'h0, r, d);
        take(32'h0000_0200);
        bus_cycle(A31, 4'b0001, 32'h0, r, d);
        check("R8 late line pending", irq_pending, B30 | B31);
        check("R8 held off", {31'b0, irq_req}, 32'h0);
        check("R8 bits unchanged", irq_bits, B30);
        ret();
        check("R8 eoi first", eoi, B30);
        check("R8 late remains", irq_pending, B31);
        check("R8 req after return", {31'b0, irq_req}, 32'h1);
        take(32'h0000_0204);
        check("R8 second bits", irq_bits, B31);
        check("R6 second ret addr", ret_addr, 32'h0000_0204);
    endtask

    task automatic t_set_during_clear();
        do_reset();
        set_mask(32'h3fff_ffff);
        begin
            logic r; logic [31:0] d;
            bus_cycle(A30, 4'b0001, 32'h0, r, d);
        end
        take(32'h0000_0300);
        cpu_retirq = 1'b1;
        bus_valid = 1'b1; bus_addr = A30; bus_wstrb = 4'b0001;
        @(negedge clk);
        cpu_retirq = 1'b0; bus_valid = 1'b0; bus_wstrb = '0;
        check("R10 eoi", eoi, B30);
        check("R10 kept set", irq_pending, B30);
        check("R10 req again", {31'b0, irq_req}, 32'h1);
    endtask

    task automatic t_masked_not_serviced();
        logic r; logic [31:0] d;
        do_reset();
        set_mask(32'hbfff_ffff);
        bus_cycle(A30, 4'b0001, 32'h0, r, d);
        bus_cycle(A31, 4'b0001, 32'h0, r, d);
        take(32'h0000_0500);
        check("R11 only unmasked", irq_bits, B30);
        ret();
        check("R11 eoi unmasked", eoi, B30);
        check("R11 masked stays", irq_pending, B31);
        check("R11 no req", {31'b0, irq_req}, 32'h0);
    endtask

    initial begin
        t_reset_state();
        t_decode_latch();
        t_ignored_accesses();
        t_mask();
        t_take_return();
        t_both_together();
        t_wait_during_handler();
        t_set_during_clear();
        t_masked_not_serviced();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule